// File: doc/BRIEF.md
# Dual-Line Subscriber Line Supervisory Controller

This block is the digital sequencer that sits beside a two-port subscriber line interface. It drives the three mode pins (`mode_d0`, `mode_d1`, `mode_d2`) and the two port-select pins (`port_p1`, `port_p2`). It reads the three active-low hook detectors, and it turns simple host commands into the pin sequences the line interface expects. In the idle state both ports sit on high-impedance feed, and the controller watches the per-port detectors. When a line goes off-hook, that port alone is switched to active feed. On a ring command the controller places the interface in ring mode and flips the polarity pin once per ring half-cycle. The flipping runs during burst windows and is held low during pause windows. A ring trip stops the flipping and moves the answering line to active feed. When both lines were rung, the answering line is found by probing one port at a time.

Every detector input passes through a two-flop synchronizer and a consecutive-sample filter before any decision uses it. On-hook is declared only after the filtered loop detector has stayed inactive for a programmable hold time. A host power-down command, or a missing supply-good indication, drives every pin low.

States: `ST_OFF` (supply not good), `ST_PDN` (host power-down), `ST_IDLE` (high-impedance monitoring), `ST_ACT` (active feed on one port), `ST_RING` (ringing), `ST_TRIP` (polarity frozen after trip), `ST_PROBE_B` (port 1 deselected), `ST_PROBE_A` (port 2 deselected).

Transitions:
- Any state goes to `ST_OFF` when supply-good is low.
- Any state goes to `ST_PDN` on the power-down command.
- `ST_OFF` and `ST_PDN` go to `ST_IDLE` once released.
- `ST_IDLE` goes to `ST_ACT` on off-hook, or to `ST_RING` on a ring command.
- `ST_ACT` goes to `ST_IDLE` once the hold time expires.
- `ST_RING` goes to `ST_TRIP` on a trip, or to `ST_IDLE` when the command is withdrawn.
- `ST_TRIP` goes to `ST_ACT` for a single-line ring, or to `ST_PROBE_B` for a both-line ring.
- `ST_PROBE_B` goes to `ST_ACT` on line 2, otherwise to `ST_PROBE_A`.
- `ST_PROBE_A` goes to `ST_ACT` on line 1, otherwise to `ST_IDLE`.

Top module: `slic_supervisor`

## Requirements
- R1: While `pwr_good` is low, all five pins are low and both line statuses read idle (code 0), whatever the detectors show.
- R2: In the idle state the pins are d0=0, d1=0, d2=0, p1=1, p2=1, and both statuses are idle (0).
- R3: A filtered off-hook on detector 1 (or detector 2) in the idle state selects active normal polarity (d0=0, d1=1, d2=0) with only that port selected (p1,p2 = 1,0 for line 1; 0,1 for line 2). That line's status becomes off-hook (code 2). Line 1 wins if both lines go off-hook together.
- R4: In active feed the block returns to idle only after the filtered loop detector has stayed inactive for TREF consecutive clocks. A shorter on-hook gap keeps the line active.
- R5: Ring mode drives d0=1 and d1=0, and selects the targeted ports (command 1 gives line 1, command 2 gives line 2, command 3 gives both). d2 toggles every HALF_CYC clocks for BURST_HC half-cycles and is held at 0 for PAUSE_HC half-cycles, so one full cadence period contains BURST_HC/2 rising edges of d2. Targeted lines report ringing (code 1). A command other than the current ring command returns the block to idle.
- R6: A ring trip is accepted only inside a burst, after BLANK_HC half-cycles of that burst have passed. The block then holds d2=0 for one clock in ring mode, and only after that enters active feed on the answering line, with status answered (code 3).
- R7: After a trip on a both-line ring, the block selects p1,p2=0,1 and tests the loop detector, then selects 1,0 and tests again. It settles in active feed on the line that answered (status 3), or in idle if neither answered.
- R8: The power-down command (code 4) drives d0, d1, p1 and p2 low on the first clock edge after it is applied, from any state. Statuses read idle. Releasing the command resumes idle monitoring.
- R9: A detector pulse shorter than DEB_N consecutive synchronized samples does not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Positive supply above its minimum level |
| host_cmd | input | 3 | 0 idle, 1 ring line 1, 2 ring line 2, 3 ring both, 4 power down |
| det_n | input | 1 | Loop or ring-trip detector, active low |
| det1_n | input | 1 | Port 1 high-impedance detector, active low |
| det2_n | input | 1 | Port 2 high-impedance detector, active low |
| mode_d0 | output | 1 | Mode pin 0 |
| mode_d1 | output | 1 | Mode pin 1 |
| mode_d2 | output | 1 | Mode pin 2 (polarity) |
| port_p1 | output | 1 | Port 1 select |
| port_p2 | output | 1 | Port 2 select |
| line1_stat | output | 2 | Line 1: 0 idle, 1 ringing, 2 off-hook, 3 answered |
| line2_stat | output | 2 | Line 2: same coding |

## Verification
The assertions assume that `pwr_good` and `host_cmd` change synchronously to the clock and stay stable for at least one cycle. They also assume the detectors behave as the line interface does: the per-port detectors are valid only in the power-down encoding, and the loop detector reflects only the selected ports. The bench keeps to this by deriving all three detector lines from a small model of hooked lines and the block's own pin outputs. It changes commands only just after a clock edge. The ring-trip stimulus deliberately lands in a pause window to show that blanking holds.

// File: rtl/slic_sup_pkg.sv
package slic_sup_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_RING1 = 3'd1,
        CMD_RING2 = 3'd2,
        CMD_RINGB = 3'd3,
        CMD_PDN   = 3'd4
    } host_cmd_e;

    typedef enum logic [1:0] {
        LS_IDLE     = 2'd0,
        LS_RINGING  = 2'd1,
        LS_OFFHOOK  = 2'd2,
        LS_ANSWERED = 2'd3
    } line_stat_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PDN,
        ST_IDLE,
        ST_ACT,
        ST_RING,
        ST_TRIP,
        ST_PROBE_B,
        ST_PROBE_A
    } sup_state_e;

endpackage

// File: rtl/slic_det_filter.sv
module slic_det_filter #(
    parameter int DEB_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic filt_n
);
    localparam int CW = $clog2(DEB_N + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            cnt    <= '0;
            filt_n <= 1'b1;
        end else begin
            s1 <= raw_n;
            s2 <= s1;
            if (s2 != filt_n) begin
                if (cnt == CW'(DEB_N - 1)) begin
                    filt_n <= s2;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    assert_filter_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_n != $past(filt_n)) |-> ($past(cnt) == CW'(DEB_N - 1)));

endmodule

// File: rtl/slic_ring_cadence.sv
module slic_ring_cadence #(
    parameter int HALF_CYC = 8,
    parameter int BURST_HC = 4,
    parameter int PAUSE_HC = 4,
    parameter int BLANK_HC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pol,
    output logic in_burst,
    output logic trip_ok
);
    localparam int TW   = $clog2(HALF_CYC + 1);
    localparam int HMAX = (BURST_HC > PAUSE_HC) ? BURST_HC : PAUSE_HC;
    localparam int HW   = $clog2(HMAX + 1);

    logic [TW-1:0] tmr;
    logic [HW-1:0] hc;
    logic          tick;

    assign tick    = (tmr == TW'(HALF_CYC - 1));
    assign trip_ok = in_burst && (hc >= HW'(BLANK_HC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr      <= '0;
            hc       <= '0;
            in_burst <= 1'b1;
            pol      <= 1'b0;
        end else if (!run) begin
            tmr      <= '0;
            hc       <= '0;
            in_burst <= 1'b1;
            pol      <= 1'b0;
        end else if (tick) begin
            tmr <= '0;
            if (in_burst) begin
                if (hc == HW'(BURST_HC - 1)) begin
                    hc       <= '0;
                    in_burst <= 1'b0;
                    pol      <= 1'b0;
                end else begin
                    hc  <= hc + 1'b1;
                    pol <= ~pol;
                end
            end else begin
                if (hc == HW'(PAUSE_HC - 1)) begin
                    hc       <= '0;
                    in_burst <= 1'b1;
                end else begin
                    hc <= hc + 1'b1;
                end
            end
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    assert_pause_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_burst |-> !pol);

endmodule

// File: rtl/slic_sup_fsm.sv
module slic_sup_fsm
    import slic_sup_pkg::*;
#(
    parameter int TREF       = 20,
    parameter int PROBE_WAIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic [2:0] cmd,
    input  logic       det_f,
    input  logic       det1_f,
    input  logic       det2_f,
    input  logic       pol,
    input  logic       trip_ok,
    output logic       ring_run,
    output logic       d0,
    output logic       d1,
    output logic       d2,
    output logic       p1,
    output logic       p2,
    output logic [1:0] stat1,
    output logic [1:0] stat2
);
    localparam int TMAX = (TREF > PROBE_WAIT) ? TREF : PROBE_WAIT;
    localparam int TMW  = $clog2(TMAX + 1);

    sup_state_e     state, nxt;
    logic           sel, nxt_sel;
    logic           ans, nxt_ans;
    logic [1:0]     tgt, nxt_tgt;
    logic [1:0]     cmd_tgt;
    logic [TMW-1:0] tmr, nxt_tmr;

    always_comb begin
        unique case (cmd)
            3'd1:    cmd_tgt = 2'b01;
            3'd2:    cmd_tgt = 2'b10;
            3'd3:    cmd_tgt = 2'b11;
            default: cmd_tgt = 2'b00;
        endcase
    end

    always_comb begin
        nxt     = state;
        nxt_sel = sel;
        nxt_ans = ans;
        nxt_tgt = tgt;
        nxt_tmr = tmr;
        if (!pwr_good) begin
            nxt = ST_OFF;
        end else if (cmd == 3'(CMD_PDN)) begin
            nxt = ST_PDN;
        end else begin
            unique case (state)
                ST_OFF, ST_PDN: nxt = ST_IDLE;
                ST_IDLE: begin
                    if (!det1_f) begin
                        nxt = ST_ACT; nxt_sel = 1'b0; nxt_ans = 1'b0; nxt_tmr = '0;
                    end else if (!det2_f) begin
                        nxt = ST_ACT; nxt_sel = 1'b1; nxt_ans = 1'b0; nxt_tmr = '0;
                    end else if (cmd_tgt != 2'b00) begin
                        nxt = ST_RING; nxt_tgt = cmd_tgt;
                    end
                end
                ST_ACT: begin
                    if (det_f) begin
                        if (tmr == TMW'(TREF - 1)) nxt = ST_IDLE;
                        else nxt_tmr = tmr + 1'b1;
                    end else begin
                        nxt_tmr = '0;
                    end
                end
                ST_RING: begin
                    if (cmd_tgt != tgt) nxt = ST_IDLE;
                    else if (trip_ok && !det_f) nxt = ST_TRIP;
                end
                ST_TRIP: begin
                    nxt_tmr = '0;
                    if (tgt == 2'b11) begin
                        nxt = ST_PROBE_B;
                    end else begin
                        nxt = ST_ACT; nxt_sel = tgt[1]; nxt_ans = 1'b1;
                    end
                end
                ST_PROBE_B: begin
                    if (tmr == TMW'(PROBE_WAIT - 1)) begin
                        nxt_tmr = '0;
                        if (!det_f) begin
                            nxt = ST_ACT; nxt_sel = 1'b1; nxt_ans = 1'b1;
                        end else begin
                            nxt = ST_PROBE_A;
                        end
                    end else begin
                        nxt_tmr = tmr + 1'b1;
                    end
                end
                ST_PROBE_A: begin
                    if (tmr == TMW'(PROBE_WAIT - 1)) begin
                        nxt_tmr = '0;
                        if (!det_f) begin
                            nxt = ST_ACT; nxt_sel = 1'b0; nxt_ans = 1'b1;
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end else begin
                        nxt_tmr = tmr + 1'b1;
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            sel   <= 1'b0;
            ans   <= 1'b0;
            tgt   <= 2'b00;
            tmr   <= '0;
        end else begin
            state <= nxt;
            sel   <= nxt_sel;
            ans   <= nxt_ans;
            tgt   <= nxt_tgt;
            tmr   <= nxt_tmr;
        end
    end

    always_comb begin
        {d0, d1, d2, p1, p2} = 5'b00000;
        stat1    = LS_IDLE;
        stat2    = LS_IDLE;
        ring_run = 1'b0;
        unique case (state)
            ST_OFF, ST_PDN: ;
            ST_IDLE: {p1, p2} = 2'b11;
            ST_ACT: begin
                d1 = 1'b1;
                p1 = !sel;
                p2 = sel;
                if (sel) stat2 = ans ? LS_ANSWERED : LS_OFFHOOK;
                else     stat1 = ans ? LS_ANSWERED : LS_OFFHOOK;
            end
            ST_RING, ST_TRIP: begin
                d0       = 1'b1;
                d2       = (state == ST_RING) ? pol : 1'b0;
                ring_run = (state == ST_RING);
                {p2, p1} = tgt;
            end
            ST_PROBE_B: begin
                d1 = 1'b1;
                p2 = 1'b1;
            end
            ST_PROBE_A: begin
                d1 = 1'b1;
                p1 = 1'b1;
            end
            default: ;
        endcase
        if (state == ST_RING || state == ST_TRIP ||
            state == ST_PROBE_B || state == ST_PROBE_A) begin
            if (tgt[0]) stat1 = LS_RINGING;
            if (tgt[1]) stat2 = LS_RINGING;
        end
    end

    assert_pins_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> ({d0, d1, d2, p1, p2} == 5'b00000));

    assert_one_port_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        d1 |-> ($onehot({p1, p2}) && !d0 && !d2));

    assert_freeze_before_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (d1 && $past(d0 && !d1)) |-> !$past(d2));

    assert_pdn_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && cmd == 3'(CMD_PDN)) |=> ({d0, d1, p1, p2} == 4'b0000));

endmodule

// File: rtl/slic_supervisor.sv
module slic_supervisor #(
    parameter int HALF_CYC = 25000,
    parameter int BURST_HC = 40,
    parameter int PAUSE_HC = 160,
    parameter int BLANK_HC = 2,
    parameter int DEB_N    = 16,
    parameter int TREF     = 200000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic [2:0] host_cmd,
    input  logic       det_n,
    input  logic       det1_n,
    input  logic       det2_n,
    output logic       mode_d0,
    output logic       mode_d1,
    output logic       mode_d2,
    output logic       port_p1,
    output logic       port_p2,
    output logic [1:0] line1_stat,
    output logic [1:0] line2_stat
);
    localparam int NDET       = 3;
    localparam int PROBE_WAIT = DEB_N + 4;

    logic [NDET-1:0] raw_n, filt_n;
    logic            pol, in_burst, trip_ok, ring_run;

    assign raw_n = {det2_n, det1_n, det_n};

    for (genvar g = 0; g < NDET; g++) begin : g_det
        slic_det_filter #(.DEB_N(DEB_N)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_n (raw_n[g]),
            .filt_n(filt_n[g])
        );
    end

    slic_ring_cadence #(
        .HALF_CYC(HALF_CYC),
        .BURST_HC(BURST_HC),
        .PAUSE_HC(PAUSE_HC),
        .BLANK_HC(BLANK_HC)
    ) u_cad (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ring_run),
        .pol     (pol),
        .in_burst(in_burst),
        .trip_ok (trip_ok)
    );

    slic_sup_fsm #(
        .TREF      (TREF),
        .PROBE_WAIT(PROBE_WAIT)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_good(pwr_good),
        .cmd     (host_cmd),
        .det_f   (filt_n[0]),
        .det1_f  (filt_n[1]),
        .det2_f  (filt_n[2]),
        .pol     (pol),
        .trip_ok (trip_ok),
        .ring_run(ring_run),
        .d0      (mode_d0),
        .d1      (mode_d1),
        .d2      (mode_d2),
        .p1      (port_p1),
        .p2      (port_p2),
        .stat1   (line1_stat),
        .stat2   (line2_stat)
    );

    assert_trip_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_d0 && !mode_d1 && $past(mode_d0 && !mode_d1 && ring_run) && !ring_run)
            |-> ($past(in_burst) || $past(host_cmd) == 3'd4 || !$past(pwr_good)));

endmodule

// File: tb/test_slic_supervisor.sv
module test_slic_supervisor;
    localparam int HALF_CYC = 8;
    localparam int BURST_HC = 4;
    localparam int PAUSE_HC = 4;
    localparam int TREF     = 20;
    localparam int PERIOD   = HALF_CYC * (BURST_HC + PAUSE_HC);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic [2:0] host_cmd = 3'd0;
    logic       det_n, det1_n, det2_n;
    logic       mode_d0, mode_d1, mode_d2, port_p1, port_p2;
    logic [1:0] line1_stat, line2_stat;
    logic       hook1 = 1'b0, hook2 = 1'b0;

    int  nchecks = 0;
    int  nfails  = 0;
    bit  done    = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    // line model: per-port detectors live only in the power-down encoding
    assign det1_n = !(!mode_d0 && !mode_d1 && port_p1 && hook1);
    assign det2_n = !(!mode_d0 && !mode_d1 && port_p2 && hook2);
    assign det_n  = (!mode_d0 && !mode_d1) ? (det1_n & det2_n)
                                           : !((port_p1 && hook1) || (port_p2 && hook2));

    slic_supervisor #(
        .HALF_CYC(HALF_CYC), .BURST_HC(BURST_HC), .PAUSE_HC(PAUSE_HC),
        .BLANK_HC(1), .DEB_N(3), .TREF(TREF)
    ) i_slic_supervisor (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .host_cmd(host_cmd),
        .det_n(det_n), .det1_n(det1_n), .det2_n(det2_n),
        .mode_d0(mode_d0), .mode_d1(mode_d1), .mode_d2(mode_d2),
        .port_p1(port_p1), .port_p2(port_p2),
        .line1_stat(line1_stat), .line2_stat(line2_stat)
    );

    function automatic logic [8:0] pack(input logic a, b, c, d, e, input logic [1:0] s1, s2);
        return {a, b, c, d, e, s1, s2};
    endfunction

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [8:0] e, g;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            g = pack(mode_d0, mode_d1, mode_d2, port_p1, port_p2, line1_stat, line2_stat);
            nchecks++;
            if (g !== e) begin
                nfails++;
                $display("FAIL %s: got %b expected %b (d0 d1 d2 p1 p2 s1 s2)", t, g, e);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_pins(input string t, input logic [8:0] e);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        #1;
    endtask

    task automatic hang_up_all();
        host_cmd = 3'd0;
        hook1 = 1'b0;
        hook2 = 1'b0;
        cyc(TREF + 20);
    endtask

    initial begin
        #1600000;
        nfails++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end

    initial begin
        cyc(3);
        expect_pins("R1 reset state", pack(0, 0, 0, 0, 0, 2'd0, 2'd0));
        rst_n = 1'b1;
        hook1 = 1'b1;
        cyc(20);
        expect_pins("R1 supply not good", pack(0, 0, 0, 0, 0, 2'd0, 2'd0));
        hook1 = 1'b0;
        pwr_good = 1'b1;
        cyc(12);
        expect_pins("R2 idle monitor", pack(0, 0, 0, 1, 1, 2'd0, 2'd0));

        // R9 short glitch on port 1
        hook1 = 1'b1; cyc(2); hook1 = 1'b0;
        cyc(15);
        expect_pins("R9 glitch ignored", pack(0, 0, 0, 1, 1, 2'd0, 2'd0));

        // R3 line 2 off-hook
        hook2 = 1'b1;
        cyc(12);
        expect_pins("R3 line2 active", pack(0, 1, 0, 0, 1, 2'd0, 2'd2));
        hang_up_all();

        // R3 simultaneous, line 1 priority
        hook1 = 1'b1; hook2 = 1'b1;
        cyc(12);
        expect_pins("R3 line1 priority", pack(0, 1, 0, 1, 0, 2'd2, 2'd0));
        hook2 = 1'b0;

        // R4 short on-hook gap
        hook1 = 1'b0; cyc(TREF / 2); hook1 = 1'b1;
        cyc(5);
        expect_pins("R4 gap keeps active", pack(0, 1, 0, 1, 0, 2'd2, 2'd0));
        hook1 = 1'b0;
        cyc(12);
        expect_pins("R4 before hold", pack(0, 1, 0, 1, 0, 2'd2, 2'd0));
        cyc(TREF);
        expect_pins("R4 after hold", pack(0, 0, 0, 1, 1, 2'd0, 2'd0));

        // R8 power-down from active
        hook1 = 1'b1;
        cyc(12);
        host_cmd = 3'd4;
        cyc(1);
        expect_pins("R8 one edge", pack(0, 0, 0, 0, 0, 2'd0, 2'd0));
        cyc(10);
        expect_pins("R8 held", pack(0, 0, 0, 0, 0, 2'd0, 2'd0));
        host_cmd = 3'd0;
        cyc(15);
        expect_pins("R8 released", pack(0, 1, 0, 1, 0, 2'd2, 2'd0));
        hang_up_all();

        // R5 ring line 2, cadence
        host_cmd = 3'd2;
        cyc(3);
        expect_pins("R5 ring encoding", pack(1, 0, 0, 0, 1, 2'd0, 2'd1));
        begin
            int rises = 0;
            logic prev = mode_d2;
            for (int i = 0; i < PERIOD; i++) begin
                @(negedge clk);
                if (mode_d2 && !prev) rises++;
                prev = mode_d2;
            end
            nchecks++;
            if (rises != BURST_HC / 2) begin
                nfails++;
                $display("FAIL R5 d2 rises: got %0d expected %0d", rises, BURST_HC / 2);
            end
        end
        #1;
        host_cmd = 3'd0;
        cyc(3);
        expect_pins("R5 withdrawn", pack(0, 0, 0, 1, 1, 2'd0, 2'd0));
        cyc(5);

        // R6 trip during pause is held off, then accepted
        host_cmd = 3'd1;
        cyc(40);
        hook1 = 1'b1;
        cyc(18);
        expect_pins("R6 blank in pause", pack(1, 0, 0, 1, 0, 2'd1, 2'd0));
        cyc(100);
        expect_pins("R6 answered line1", pack(0, 1, 0, 1, 0, 2'd3, 2'd0));
        hang_up_all();

        // R7 both rung, line 2 answers
        host_cmd = 3'd3;
        cyc(10);
        hook2 = 1'b1;
        cyc(150);
        expect_pins("R7 probe finds line2", pack(0, 1, 0, 0, 1, 2'd0, 2'd3));
        hang_up_all();

        // R7 both rung, line 1 answers
        host_cmd = 3'd3;
        cyc(10);
        hook1 = 1'b1;
        cyc(150);
        expect_pins("R7 probe finds line1", pack(0, 1, 0, 1, 0, 2'd3, 2'd0));
        hang_up_all();
        expect_pins("R2 idle again", pack(0, 0, 0, 1, 1, 2'd0, 2'd0));

        cyc(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end
endmodule